// File: doc/BRIEF.md
# Pulse-Distribution PWM Generator

The block drives eight PWM outputs from one shared timebase. Each channel holds an 8-bit code. The code is split into two nibbles:

- The upper nibble sets how long a short basic pulse stays high. That pulse repeats sixteen times per conversion period.
- The lower nibble chooses how many of those sixteen pulses stay high for one extra counting clock.

The average high fraction over a period is therefore code/256, from 0/256 up to 255/256. Extra clocks go to the basic pulses whose bit-reversed index is below the lower nibble, so they are spread evenly through the period. Because of this, a simple low-pass filter on the output sees little ripple at the period rate.

The counting clock is the system clock divided by 1, 2, 4, 8 or 16, chosen through a 3-bit select input, or it can be stopped. A code written into a channel is held in a pending register. It takes effect at the next wrap of the shared 8-bit counter, so a period already under way is never cut into. When the timebase is stopped, the counter and prescaler stay at zero and every output is low.

Top module: `pdpwm_top`

## Requirements
- R1: A write (`wr_en` high at a clock edge) stores `wr_data` into the pending code of channel `wr_ch`. `rd_data` always shows the pending code of channel `rd_ch`.
- R2: `clk_sel` encoding is as follows. Values 1, 2, 3, 4 and 5 divide the system clock by 1, 2, 4, 8 and 16. Values 0, 6 and 7 stop the timebase. The counter advances once per divided tick.
- R3: In a cycle where `clk_sel` differs from the value sampled at the previous edge, no tick occurs and the prescaler restarts from zero. The first tick under the new setting comes a full division later.
- R4: The counter is 8 bits wide and wraps from 255 to 0, so a conversion period is 256 ticks. Counter bits [7:4] give the basic-pulse index and bits [3:0] give the phase within that pulse.
- R5: For a channel whose code is U in the upper nibble and L in the lower, each basic pulse is high from phase 0 for U ticks. A code of zero gives a constant low output.
- R6: A basic pulse whose 4-bit index, bit-reversed, is less than L is high for U+1 ticks. Over one period the output is high for exactly 16·U+L ticks.
- R7: A code written while the timebase runs takes effect at the tick that wraps the counter to 0. While the timebase is stopped, the written code is adopted on the following cycle.
- R8: While the timebase is stopped, the counter and prescaler are held at zero and all outputs are low.
- R9: After reset, all pending codes are zero, the timebase is stopped and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for a channel code |
| wr_ch | input | 3 | Channel addressed by a write |
| wr_data | input | 8 | Code to write (upper nibble: duty, lower nibble: extra count) |
| rd_ch | input | 3 | Channel whose pending code is shown on `rd_data` |
| rd_data | output | 8 | Pending code of channel `rd_ch` |
| clk_sel | input | 3 | Counting-clock divider select; 0, 6 and 7 stop the timebase |
| pwm_o | output | 8 | PWM outputs, one bit per channel |

## Verification
The assertions assume that `clk_sel` and the write inputs are stable across each rising edge, and that `wr_ch` and `rd_ch` only address existing channels. The stimulus drives every input on the falling edge and only uses channel numbers 0 to 7.

The assertions also assume that reset is held long enough for the two-stage synchronizer to clear. The bench keeps reset low for three cycles and issues nothing until four cycles after release.

Select changes are made both far apart and back-to-back a few cycles apart. This exercises the prescaler restart without leaving the legal code range.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    CS_OFF = 3'd0,
    CS_D1  = 3'd1,
    CS_D2  = 3'd2,
    CS_D4  = 3'd3,
    CS_D8  = 3'd4,
    CS_D16 = 3'd5
  } clk_sel_e;
endpackage

// File: rtl/pdpwm_timebase.sv
module pdpwm_timebase
  import pdpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic             chg_o,
  output logic             tick_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PS_W-1:0]  presc_o
);
  localparam int MAX_SEL = PS_W + 1;

  logic [SEL_W-1:0] sel_q;
  logic [PS_W-1:0]  presc_q, presc_d, mask;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en, chg, tick;

  // divider decode: select value s>0 gives a terminal count of 2^(s-1)-1
  always_comb begin
    en   = (sel_q != '0) && (int'(sel_q) <= MAX_SEL);
    mask = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (i + 1 < int'(sel_q)) mask[i] = 1'b1;
    end
    chg  = (sel_i != sel_q);
    tick = en && !chg && (presc_q == mask);
  end

  always_comb begin
    presc_d = (!en || chg || tick) ? '0 : presc_q + 1'b1;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= CS_OFF;
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      sel_q   <= sel_i;
      presc_q <= presc_d;
      if (!en || tick) cnt_q <= cnt_d;
    end
  end

  assign en_o    = en;
  assign chg_o   = chg;
  assign tick_o  = tick;
  assign wrap_o  = tick && (cnt_q == '1);
  assign cnt_o   = cnt_q;
  assign presc_o = presc_q;
endmodule

// File: rtl/pdpwm_regs.sv
module pdpwm_regs #(
  parameter int N_CH = 8,
  parameter int DW   = 8,
  parameter int CH_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CH_W-1:0]           wr_ch,
  input  logic [DW-1:0]             wr_data,
  input  logic [CH_W-1:0]           rd_ch,
  output logic [DW-1:0]             rd_data,
  input  logic                      load,
  output logic [N_CH-1:0][DW-1:0]   act_o
);
  logic [N_CH-1:0][DW-1:0] pend_q;
  logic [N_CH-1:0][DW-1:0] act_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= '0;
        act_q[g]  <= '0;
      end else begin
        if (hit)  pend_q[g] <= wr_data;
        if (load) act_q[g]  <= pend_q[g];
      end
    end
  end

  assign rd_data = pend_q[rd_ch];
  assign act_o   = act_q;
endmodule

// File: rtl/pdpwm_chan.sv
module pdpwm_chan #(
  parameter int DW = 8
) (
  input  logic          en,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] code,
  output logic          pwm
);
  localparam int H = DW / 2;

  logic [H-1:0] idx, phase, idx_rev;
  logic         extra;
  logic [H:0]   limit;

  always_comb begin
    idx   = cnt[DW-1:H];
    phase = cnt[H-1:0];
    for (int b = 0; b < H; b++) idx_rev[b] = idx[H-1-b];
    extra = (idx_rev < code[H-1:0]);
    limit = {1'b0, code[DW-1:H]} + {{H{1'b0}}, extra};
    pwm   = en && ({1'b0, phase} < limit);
  end
endmodule

// File: rtl/pdpwm_top.sv
module pdpwm_top
  import pdpwm_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int DW   = 8,
  parameter int PS_W = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [DW-1:0]    wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [DW-1:0]    rd_data,
  input  logic [SEL_W-1:0] clk_sel,
  output logic [N_CH-1:0]  pwm_o
);
  logic                    rs1_q, rs2_q, rst_s_n;
  logic                    tb_en, tb_chg, tb_tick, tb_wrap;
  logic [DW-1:0]           tb_cnt;
  logic [PS_W-1:0]         tb_presc;
  logic [N_CH-1:0][DW-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  pdpwm_timebase #(.CNT_W(DW), .PS_W(PS_W)) u_tb (
    .clk(clk), .rst_n(rst_s_n), .sel_i(clk_sel),
    .en_o(tb_en), .chg_o(tb_chg), .tick_o(tb_tick), .wrap_o(tb_wrap),
    .cnt_o(tb_cnt), .presc_o(tb_presc)
  );

  pdpwm_regs #(.N_CH(N_CH), .DW(DW), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data),
    .load(tb_wrap || !tb_en), .act_o(act)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_out
    pdpwm_chan #(.DW(DW)) u_chan (
      .en(tb_en), .cnt(tb_cnt), .code(act[g]), .pwm(pwm_o[g])
    );
  end
endmodule

// File: rtl/pdpwm_chk.sv
module pdpwm_chk #(
  parameter int N_CH = 8,
  parameter int DW   = 8,
  parameter int PS_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    chg,
  input logic                    tick,
  input logic                    wrap,
  input logic [DW-1:0]           cnt,
  input logic [PS_W-1:0]         presc,
  input logic [N_CH-1:0][DW-1:0] act,
  input logic [N_CH-1:0]         pwm
);
  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm == '0));

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0) && (presc == '0));

  // R3
  sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (presc == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == DW'($past(cnt) + 1'b1)));

  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(act));

  for (genvar g = 0; g < N_CH; g++) begin : g_zero
    // R5
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act[g] == '0) |-> !pwm[g]);
  end
endmodule

bind pdpwm_top pdpwm_chk #(.N_CH(N_CH), .DW(DW), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .en(tb_en), .chg(tb_chg), .tick(tb_tick),
  .wrap(tb_wrap), .cnt(tb_cnt), .presc(tb_presc), .act(act), .pwm(pwm_o)
);

// File: tb/pdpwm_top_tb.sv
module pdpwm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_ch;
  logic [7:0] wr_data;
  logic [2:0] rd_ch;
  logic [7:0] rd_data;
  logic [2:0] clk_sel;
  logic [7:0] pwm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_on = 0;
  string cur_req = "R5";

  always #2 clk = ~clk;

  pdpwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .clk_sel(clk_sel), .pwm_o(pwm_o)
  );

  // behavioural reference model
  int         m_sel, m_presc, m_cnt, rs_cnt;
  logic [7:0] m_sh [8];
  logic [7:0] m_act [8];
  logic [7:0] m_old [8];

  function automatic bit m_en(int s);
    return (s >= 1) && (s <= 5);
  endfunction

  function automatic bit m_exp(int ch);
    int idx, ph, r, hi;
    if (!m_en(m_sel)) return 1'b0;
    idx = m_cnt / 16;
    ph  = m_cnt % 16;
    r   = 0;
    for (int b = 0; b < 4; b++) if ((idx >> b) & 1) r = r | (1 << (3 - b));
    hi = int'(m_act[ch][7:4]) + ((r < int'(m_act[ch][3:0])) ? 1 : 0);
    return ph < hi;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_presc = 0; m_cnt = 0; rs_cnt = 0;
      for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    end else if (rs_cnt < 2) begin
      rs_cnt++;
    end else begin
      bit en, chg, tick;
      int div;
      en   = m_en(m_sel);
      div  = en ? (1 << (m_sel - 1)) : 1;
      chg  = (int'(clk_sel) != m_sel);
      tick = en && !chg && (m_presc == div - 1);
      m_old = m_sh;
      if (wr_en) m_sh[wr_ch] = wr_data;
      if (!en || (tick && m_cnt == 255)) m_act = m_old;
      if (!en || chg || tick) m_presc = 0; else m_presc++;
      if (!en) m_cnt = 0; else if (tick) m_cnt = (m_cnt + 1) % 256;
      m_sel = int'(clk_sel);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int c = 0; c < 8; c++) begin
        checks++;
        if (pwm_o[c] !== m_exp(c)) begin
          errors++;
          $display("FAIL %s ch%0d cnt=%0d pwm got %b exp %b", cur_req, c, m_cnt, pwm_o[c], m_exp(c));
        end
      end
    end
  end

  task automatic check(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wr(int ch, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 3'(ch); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic readback(string req);
    for (int c = 0; c < 8; c++) begin
      rd_ch = 3'(c);
      #1;
      check(rd_data === m_sh[c], req, int'(rd_data), int'(m_sh[c]));
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] codes [8] = '{8'h00, 8'h10, 8'h01, 8'h35, 8'h8F, 8'hF0, 8'hFF, 8'h7A};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0; clk_sel = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    // R9 reset state
    check(pwm_o == 8'h00, "R9", int'(pwm_o), 0);
    readback("R9");
    cmp_on = 1;

    // R1 and R8: load codes while stopped
    cur_req = "R8";
    for (int c = 0; c < 8; c++) wr(c, codes[c]);
    readback("R1");
    cycles(5);
    check(pwm_o == 8'h00, "R8", int'(pwm_o), 0);

    // R5/R6: divide by 1, full period counts
    cur_req = "R5";
    clk_sel = 3'd1;
    cycles(300);
    cur_req = "R6";
    begin
      int hi [8];
      int rises;
      bit prev;
      for (int c = 0; c < 8; c++) hi[c] = 0;
      rises = 0; prev = 1'b0;
      do @(negedge clk); while (m_cnt != 0);
      for (int k = 0; k < 256; k++) begin
        for (int c = 0; c < 8; c++) hi[c] += int'(pwm_o[c]);
        if (pwm_o[1] && !prev) rises++;
        prev = pwm_o[1];
        @(negedge clk);
      end
      for (int c = 0; c < 8; c++)
        check(hi[c] == 16 * int'(codes[c][7:4]) + int'(codes[c][3:0]), "R6",
              hi[c], 16 * int'(codes[c][7:4]) + int'(codes[c][3:0]));
      // R4: code 0x10 gives one pulse per 16 ticks
      check(rises == 16, "R4", rises, 16);
    end

    // R7: mid-period write waits for the wrap
    cur_req = "R7";
    do @(negedge clk); while (m_cnt != 100);
    wr(3, 8'hC4);
    readback("R1");
    cycles(400);

    // R2: other dividers
    cur_req = "R2";
    clk_sel = 3'd3;
    cycles(1200);
    clk_sel = 3'd5;
    cycles(4300);
    clk_sel = 3'd2;
    cycles(700);

    // R3: rapid select changes
    cur_req = "R3";
    for (int i = 0; i < 40; i++) begin
      clk_sel = 3'(1 + (i % 5));
      cycles(3 + (i % 7));
    end
    clk_sel = 3'd4;
    cycles(2200);

    // R8: stop, write while stopped, resume
    cur_req = "R8";
    clk_sel = 3'd0;
    cycles(30);
    check(pwm_o == 8'h00, "R8", int'(pwm_o), 0);
    wr(0, 8'h9B);
    cur_req = "R2";
    clk_sel = 3'd7;
    cycles(20);
    check(pwm_o == 8'h00, "R2", int'(pwm_o), 0);
    clk_sel = 3'd6;
    cycles(20);
    check(pwm_o == 8'h00, "R2", int'(pwm_o), 0);
    cur_req = "R7";
    clk_sel = 3'd1;
    cycles(600);

    cmp_on = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule